// File: doc/BRIEF.md
# Parallel-Bus Command Script Player

This block drives an external USB device-interface controller through an 8-bit write-only parallel bus. It has a single address line that picks the command register or the data register. It holds two fixed scripts, and each script entry is a byte plus a tag that marks it as a command or a data byte. A command byte always goes to the command address, and the data bytes that the command takes follow it at the data address.

The bring-up script runs once, without a request, as soon as reset is released. It selects the transfer setting and then the operating mode, and writes the mode and clock-divider values after them. The control-endpoint acknowledge script runs each time a one-cycle request arrives while the block is idle. It consists only of commands: it selects the outbound control endpoint, acknowledges the setup stage and empties that endpoint's buffer, then selects the inbound control endpoint and acknowledges again. The block sets the bus timing itself. It raises a one-cycle completion pulse, tagged with the script that just ended.

Top module: `usb_cmd_seq`

## Requirements
- R1: After reset is released, the bring-up script plays without any request. It consists of exactly five writes, followed by one completion pulse with `done_id`=0.
- R2: With default parameters, the bring-up writes are, in order (byte, `bus_a0`): (0xFB,1), (0xC0,0), (0xF3,1), (0x16,0), (0x47,0). `bus_a0`=1 addresses the command register and 0 addresses the data register.
- R3: A one-cycle `ack_req` while idle plays the acknowledge script. It consists of five command writes (`bus_a0`=1) with the bytes 0x00, 0xF1, 0xF2, 0x01, 0xF1, followed by one completion pulse with `done_id`=1.
- R4: For every write, `bus_d` and `bus_a0` already hold the write's values in the cycle before `bus_wr_n` falls. They stay unchanged while the strobe is low and in the cycle in which it rises.
- R5: `bus_wr_n` stays low for exactly STROBE_CYC consecutive cycles per write.
- R6: Within a script, `bus_wr_n` stays high for exactly GAP_CYC+2 cycles between two consecutive strobes.
- R7: `done` is high for exactly one cycle. That cycle is the second high cycle after the final strobe, and `busy` is low in it.
- R8: `ack_req` pulses that arrive while `busy` is high have no effect: they cause no extra writes and no extra completion pulse.
- R9: The bring-up script does not run again after its first run, unless reset is applied again. Reset applied in the middle of a script aborts that script and restarts the bring-up script.
- R10: While reset is held, `bus_wr_n`=1, `done`=0, `bus_d`=0 and `bus_a0`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ack_req | input | 1 | Request to play the acknowledge script |
| bus_d | output | 8 | Byte on the parallel bus, 0 when idle |
| bus_a0 | output | 1 | Address select: 1 = command register, 0 = data register |
| bus_wr_n | output | 1 | Active-low write strobe |
| busy | output | 1 | A script is pending or in progress |
| done | output | 1 | One-cycle completion pulse |
| done_id | output | 1 | Script that finished: 0 = bring-up, 1 = acknowledge |

## Verification
The bench watches every cycle for an address or data change near a strobe edge. A design that moves the bus in the setup cycle or the hold cycle corrupts the byte latched by the peripheral. Strobe widths and inter-write gaps are counted one by one, so an off-by-one in either counter shows up as a wrong width. Requests are issued in the middle of a script and again right after it ends. A design that restarts early, queues the request, or runs the bring-up script a second time produces a write count or a completion count that does not match. A reset issued in the middle of a script checks that the bring-up script, not the interrupted one, resumes with correct contents.

// File: rtl/usb_cmd_seq.sv
module usb_cmd_seq #(
  parameter int          STROBE_CYC  = 3,
  parameter int          GAP_CYC     = 2,
  parameter logic [7:0]  CMD_XFER    = 8'hFB,
  parameter logic [7:0]  XFER_CFG    = 8'hC0,
  parameter logic [7:0]  CMD_MODE    = 8'hF3,
  parameter logic [7:0]  MODE_CFG    = 8'h16,
  parameter logic [7:0]  CLK_CFG     = 8'h47,
  parameter logic [7:0]  CMD_SEL_OUT = 8'h00,
  parameter logic [7:0]  CMD_ACK     = 8'hF1,
  parameter logic [7:0]  CMD_CLR     = 8'hF2,
  parameter logic [7:0]  CMD_SEL_IN  = 8'h01
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ack_req,
  output logic [7:0] bus_d,
  output logic       bus_a0,
  output logic       bus_wr_n,
  output logic       busy,
  output logic       done,
  output logic       done_id
);
  localparam int LEN  = 5;
  localparam int MAXC = (STROBE_CYC > GAP_CYC) ? STROBE_CYC : GAP_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_STRB, S_HOLD, S_GAP} st_t;

  st_t           st;
  logic [2:0]    idx;
  logic [CW-1:0] cnt;
  logic          sel, boot_pend;
  logic [8:0]    ent;

  function automatic logic [8:0] entry(input logic s, input logic [2:0] i);
    case ({s, i})
      4'b0_000: entry = {1'b1, CMD_XFER};
      4'b0_001: entry = {1'b0, XFER_CFG};
      4'b0_010: entry = {1'b1, CMD_MODE};
      4'b0_011: entry = {1'b0, MODE_CFG};
      4'b0_100: entry = {1'b0, CLK_CFG};
      4'b1_000: entry = {1'b1, CMD_SEL_OUT};
      4'b1_001: entry = {1'b1, CMD_ACK};
      4'b1_010: entry = {1'b1, CMD_CLR};
      4'b1_011: entry = {1'b1, CMD_SEL_IN};
      4'b1_100: entry = {1'b1, CMD_ACK};
      default:  entry = 9'd0;
    endcase
  endfunction

  assign ent      = entry(sel, idx);
  assign bus_d    = (st == S_IDLE) ? 8'd0 : ent[7:0];
  assign bus_a0   = (st == S_IDLE) ? 1'b0 : ent[8];
  assign bus_wr_n = (st != S_STRB);
  assign busy     = (st != S_IDLE) || boot_pend;
  assign done_id  = sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      idx       <= '0;
      cnt       <= '0;
      sel       <= 1'b0;
      boot_pend <= 1'b1;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: begin
          idx <= '0;
          if (boot_pend) begin
            sel       <= 1'b0;
            boot_pend <= 1'b0;
            st        <= S_SETUP;
          end else if (ack_req) begin
            sel <= 1'b1;
            st  <= S_SETUP;
          end
        end
        S_SETUP: begin
          cnt <= '0;
          st  <= S_STRB;
        end
        S_STRB: begin
          if (cnt == CW'(STROBE_CYC - 1)) begin
            cnt <= '0;
            st  <= S_HOLD;
          end else cnt <= cnt + 1'b1;
        end
        S_HOLD: begin
          cnt <= '0;
          if (idx == 3'(LEN - 1)) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end else st <= S_GAP;
        end
        S_GAP: begin
          if (cnt == CW'(GAP_CYC - 1)) begin
            cnt <= '0;
            idx <= idx + 1'b1;
            st  <= S_SETUP;
          end else cnt <= cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_setup_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_wr_n) |-> $stable(bus_d) && $stable(bus_a0));
  p_hold_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_wr_n) |-> $stable(bus_d) && $stable(bus_a0));
  p_ack_all_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr_n && done_id) |-> bus_a0);
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && bus_wr_n);
  p_req_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ack_req) |=> $stable(done_id));
endmodule

// File: tb/sim_usb_cmd_seq.sv
`timescale 1ns/1ps
module sim_usb_cmd_seq;
  localparam int STB = 3;
  localparam int GAP = 2;

  logic clk = 1'b0, rst_n = 1'b0, ack_req = 1'b0;
  logic [7:0] bus_d;
  logic bus_a0, bus_wr_n, busy, done, done_id;

  always #2.5 clk = ~clk;

  usb_cmd_seq #(.STROBE_CYC(STB), .GAP_CYC(GAP)) u0 (
    .clk(clk), .rst_n(rst_n), .ack_req(ack_req), .bus_d(bus_d),
    .bus_a0(bus_a0), .bus_wr_n(bus_wr_n), .busy(busy), .done(done),
    .done_id(done_id));

  int mchk = 0, mbad = 0, tchk = 0, tbad = 0;
  logic [7:0] wbyte [0:63];
  logic       wa0   [0:63];
  int nwr = 0, ndone = 0;
  logic lastid;

  task automatic mcheck(string tag, int act, int exp);
    mchk++;
    if (act != exp) begin
      mbad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tcheck(string tag, int act, int exp);
    tchk++;
    if (act != exp) begin
      tbad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  logic pw = 1'b1, pa0 = 1'b0, pdone = 1'b0, sa0 = 1'b0, inscr = 1'b0;
  logic [7:0] pd = 8'd0, sd = 8'd0;
  int lowc = 0, hicnt = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      pw = 1'b1; pdone = 1'b0; inscr = 1'b0; hicnt = 0; lowc = 0;
    end else begin
      if (!bus_wr_n && pw) begin
        mcheck("R4 setup a0", pa0, bus_a0);
        mcheck("R4 setup data", pd, bus_d);
        if (inscr) mcheck("R6 gap", hicnt, GAP + 2);
        lowc = 1; sa0 = bus_a0; sd = bus_d; inscr = 1'b1;
      end else if (!bus_wr_n) begin
        lowc++;
        mcheck("R4 strobe data", bus_d, sd);
        mcheck("R4 strobe a0", bus_a0, sa0);
      end else if (!pw) begin
        mcheck("R5 strobe width", lowc, STB);
        mcheck("R4 hold data", bus_d, sd);
        mcheck("R4 hold a0", bus_a0, sa0);
        if (nwr < 64) begin wbyte[nwr] = sd; wa0[nwr] = sa0; end
        nwr++;
        hicnt = 1;
      end else hicnt++;
      if (done) begin
        mcheck("R7 done position", hicnt, 2);
        mcheck("R7 busy low at done", busy, 0);
        inscr = 1'b0; ndone++; lastid = done_id;
      end
      if (pdone) mcheck("R7 single pulse", done, 0);
      pw = bus_wr_n; pa0 = bus_a0; pd = bus_d; pdone = done;
    end
  end

  task automatic wait_done(input int d0);
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (ndone != d0) break;
    end
  endtask

  task automatic pulse_req;
    @(negedge clk) ack_req = 1'b1;
    @(negedge clk) ack_req = 1'b0;
  endtask

  task automatic check_connect(input int base, string tag);
    logic [7:0] eb [0:4];
    logic       ea [0:4];
    eb = '{8'hFB, 8'hC0, 8'hF3, 8'h16, 8'h47};
    ea = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b0};
    tcheck({tag, " write count"}, nwr - base, 5);
    for (int i = 0; i < 5; i++) begin
      tcheck({tag, " R2 byte"}, wbyte[base+i], eb[i]);
      tcheck({tag, " R2 a0"}, wa0[base+i], ea[i]);
    end
    tcheck({tag, " done_id"}, lastid, 0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    tcheck("R10 wr_n", bus_wr_n, 1);
    tcheck("R10 done", done, 0);
    tcheck("R10 data", bus_d, 0);
    tcheck("R10 a0", bus_a0, 0);
  endtask

  task automatic t_boot;
    int base = nwr, d0 = ndone;
    @(negedge clk) rst_n = 1'b1;
    wait_done(d0);
    tcheck("R1 one done", ndone - d0, 1);
    check_connect(base, "R1");
  endtask

  task automatic t_ack;
    int base = nwr, d0 = ndone;
    logic [7:0] eb [0:4];
    eb = '{8'h00, 8'hF1, 8'hF2, 8'h01, 8'hF1};
    pulse_req();
    wait_done(d0);
    tcheck("R3 one done", ndone - d0, 1);
    tcheck("R3 write count", nwr - base, 5);
    for (int i = 0; i < 5; i++) begin
      tcheck("R3 byte", wbyte[base+i], eb[i]);
      tcheck("R3 a0 command", wa0[base+i], 1);
    end
    tcheck("R3 done_id", lastid, 1);
  endtask

  task automatic t_busy_ignore;
    int base = nwr, d0 = ndone;
    pulse_req();
    repeat (6) @(negedge clk);
    pulse_req();
    repeat (10) @(negedge clk);
    pulse_req();
    wait_done(d0);
    repeat (40) @(negedge clk);
    tcheck("R8 writes", nwr - base, 5);
    tcheck("R8 done count", ndone - d0, 1);
    tcheck("R8 busy idle", busy, 0);
  endtask

  task automatic t_no_rerun;
    int base = nwr, d0 = ndone;
    repeat (100) @(negedge clk);
    tcheck("R9 no writes", nwr - base, 0);
    tcheck("R9 no done", ndone - d0, 0);
  endtask

  task automatic t_reset_mid;
    int base, d0;
    pulse_req();
    repeat (8) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    tcheck("R10 mid wr_n", bus_wr_n, 1);
    base = nwr; d0 = ndone;
    @(negedge clk) rst_n = 1'b1;
    wait_done(d0);
    tcheck("R9 restart done", ndone - d0, 1);
    check_connect(base, "R9");
  endtask

  bit wd_hit = 1'b0;
  initial begin
    #(200000 * 5);
    wd_hit = 1'b1;
    tchk++; tbad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", mchk + tchk, mbad + tbad);
    $finish;
  end

  initial begin
    t_reset();
    t_boot();
    repeat (5) @(negedge clk);
    t_ack();
    t_busy_ignore();
    t_no_rerun();
    t_reset_mid();
    t_ack();
    repeat (5) @(negedge clk);
    if (!wd_hit) begin
      $display("  test done: total=%0d bad=%0d", mchk + tchk, mbad + tbad);
      $finish;
    end
  end
endmodule